// File: doc/BRIEF.md
# Subtract-and-Branch Single-Instruction Core

This block is a small 8-bit processor whose only instruction subtracts one memory word from another and branches when the difference is not positive. Every instruction occupies three consecutive words holding operand addresses A and B and a branch target C. A fixed six-step sequencer first reads those three words. It then reads the value at A and the value at B, and writes the difference (value at B minus value at A) back to B. The instruction pointer then either loads C or moves forward by three words.

The core drives one address bus, a write-data bus with its own drive enable, and separate read and write strobes. It expects memory that returns read data in the same cycle as the address and read strobe. A write to the top few addresses also raises an IO strobe, so a latch-style output port can capture the value. Memory, address decoding and peripherals sit outside the block.

The branch decision uses only the subtractor: the borrow of a subtraction whose sign bits have been flipped, combined with a NOR-based zero test of the difference. No separate comparator is involved.

Top module: `oisc_core`

## Requirements
- R1: Reset is synchronous and active high. It clears the instruction pointer to 0 and restarts the sequence, even when asserted in the middle of an instruction. The first bus cycle after reset reads address 0.
- R2: Each instruction takes exactly six clocks. In order, the bus addresses are IP, IP+1, IP+2, A, B and B. `rd_en` is high in the first five clocks, and `wr_en` is high only in the sixth.
- R3: In the sixth clock, `bus_wdata` carries (value at B − value at A) modulo 256, and this value is stored at address B.
- R4: When the value at B is greater than the value at A, both read as signed 8-bit numbers, the next instruction is fetched from IP+3 (modulo the address space).
- R5: When the value at B is less than or equal to the value at A, the next instruction is fetched from C. This includes the case of a zero result.
- R6: The operand −128 (0x80) never traps. The result wraps modulo 256, and the branch still follows the true signed comparison of R4/R5. For example, 0 − (−128) stores 0x80 and falls through, and −128 − 1 stores 0x7F and branches.
- R7: `io_stb` is high exactly in the write clock when B lies in the top `IO_WORDS` addresses (B ≥ 248 by default). It is low in every other clock.
- R8: `bus_wdata_oe` is high only together with `wr_en`, and never while `rd_en` is high.
- R9: A program made of the words 0 0 0 at address 0 repeats forever at address 0, writing 0 on each pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | output | ADDR_W | Word address for the current bus cycle |
| bus_rdata | input | DATA_W | Read data returned by memory in the same cycle |
| bus_wdata | output | DATA_W | Write data (the subtraction result) |
| bus_wdata_oe | output | 1 | Core drives the data bus |
| rd_en | output | 1 | Read strobe |
| wr_en | output | 1 | Write strobe |
| io_stb | output | 1 | Write strobe for the IO address window |

## Verification
A corrupted phase counter shows up within one instruction: the address pattern of the six-clock frame shifts, or `wr_en` appears in the wrong slot. A wrong operand register or subtraction result appears on `bus_wdata` in the write clock of the same instruction. A wrong branch decision or instruction-pointer update is visible one clock later, as the address of the next fetch. Directed instructions cover equal, smaller, larger and −128 operands, so each branch outcome is observed at the next fetch.

// File: rtl/oisc_pkg.sv
`timescale 1ns/1ps
package oisc_pkg;
  typedef enum logic [2:0] {
    PH_FETCH_A = 3'd0,
    PH_FETCH_B = 3'd1,
    PH_FETCH_C = 3'd2,
    PH_READ_A  = 3'd3,
    PH_READ_B  = 3'd4,
    PH_WRITE   = 3'd5
  } phase_t;
endpackage

// File: rtl/oisc_seq.sv
`timescale 1ns/1ps
module oisc_seq
  import oisc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_t phase
);
  phase_t phase_q;
  phase_t phase_d;

  always_comb begin
    case (phase_q)
      PH_FETCH_A: phase_d = PH_FETCH_B;
      PH_FETCH_B: phase_d = PH_FETCH_C;
      PH_FETCH_C: phase_d = PH_READ_A;
      PH_READ_A:  phase_d = PH_READ_B;
      PH_READ_B:  phase_d = PH_WRITE;
      default:    phase_d = PH_FETCH_A;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_FETCH_A;
    else     phase_q <= phase_d;
  end

  assign phase = phase_q;

  // six-step frame closes back to the first fetch
  assert_frame_wraps_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WRITE) |=> (phase_q == PH_FETCH_A));

  assert_reset_restarts_R1: assert property (@(posedge clk)
    rst |=> (phase_q == PH_FETCH_A));
endmodule

// File: rtl/oisc_ip.sv
`timescale 1ns/1ps
module oisc_ip #(
  parameter int ADDR_W = 8,
  parameter int STEP   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              take_jump,
  input  logic [ADDR_W-1:0] jump_addr,
  output logic [ADDR_W-1:0] ip
);
  localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(STEP);

  logic [ADDR_W-1:0] ip_q;

  always_ff @(posedge clk) begin
    if (rst)            ip_q <= '0;
    else if (advance)   ip_q <= take_jump ? jump_addr : ip_q + STEP_W;
  end

  assign ip = ip_q;

  assert_ip_cleared_R1: assert property (@(posedge clk)
    rst |=> (ip_q == '0));

  assert_ip_steps_R4: assert property (@(posedge clk) disable iff (rst)
    (advance && !take_jump) |=> (ip_q == $past(ip_q) + STEP_W));

  assert_ip_jumps_R5: assert property (@(posedge clk) disable iff (rst)
    (advance && take_jump) |=> (ip_q == $past(jump_addr)));

  assert_ip_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(ip_q));
endmodule

// File: rtl/oisc_alu.sv
`timescale 1ns/1ps
module oisc_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] minuend,
  input  logic [DATA_W-1:0] subtrahend,
  output logic [DATA_W-1:0] diff,
  output logic              le
);
  localparam logic [DATA_W-1:0] SIGN_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W:0] wide;
  logic            borrow;
  logic            zero;

  // Flipping both sign bits maps signed order onto unsigned order, so the
  // borrow is a signed "less than" while the low bits stay the true difference.
  always_comb begin
    wide   = {1'b0, minuend ^ SIGN_BIT} - {1'b0, subtrahend ^ SIGN_BIT};
    borrow = wide[DATA_W];
    diff   = wide[DATA_W-1:0];
    zero   = ~|diff;
    le     = borrow | zero;
  end
endmodule

// File: rtl/oisc_core.sv
`timescale 1ns/1ps
module oisc_core
  import oisc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int IO_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wdata_oe,
  output logic              rd_en,
  output logic              wr_en,
  output logic              io_stb
);
  localparam int              STEP    = 3;
  localparam logic [ADDR_W-1:0] IO_BASE = ADDR_W'((1 << ADDR_W) - IO_WORDS);

  phase_t            phase;
  logic [ADDR_W-1:0] ip;
  logic [ADDR_W-1:0] a_reg, b_reg, c_reg;
  logic [DATA_W-1:0] opa_reg, res_reg;
  logic              le_reg;
  logic [DATA_W-1:0] alu_diff;
  logic              alu_le;

  oisc_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .phase (phase)
  );

  oisc_ip #(.ADDR_W(ADDR_W), .STEP(STEP)) u_ip (
    .clk       (clk),
    .rst       (rst),
    .advance   (phase == PH_WRITE),
    .take_jump (le_reg),
    .jump_addr (c_reg),
    .ip        (ip)
  );

  oisc_alu #(.DATA_W(DATA_W)) u_alu (
    .minuend    (bus_rdata),
    .subtrahend (opa_reg),
    .diff       (alu_diff),
    .le         (alu_le)
  );

  // operand and result registers, loaded in their own phase only
  always_ff @(posedge clk) begin
    if (rst) begin
      a_reg   <= '0;
      b_reg   <= '0;
      c_reg   <= '0;
      opa_reg <= '0;
      res_reg <= '0;
      le_reg  <= 1'b0;
    end else begin
      case (phase)
        PH_FETCH_A: a_reg   <= ADDR_W'(bus_rdata);
        PH_FETCH_B: b_reg   <= ADDR_W'(bus_rdata);
        PH_FETCH_C: c_reg   <= ADDR_W'(bus_rdata);
        PH_READ_A:  opa_reg <= bus_rdata;
        PH_READ_B: begin
          res_reg <= alu_diff;
          le_reg  <= alu_le;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (phase)
      PH_FETCH_A: bus_addr = ip;
      PH_FETCH_B: bus_addr = ip + ADDR_W'(1);
      PH_FETCH_C: bus_addr = ip + ADDR_W'(2);
      PH_READ_A:  bus_addr = a_reg;
      default:    bus_addr = b_reg;
    endcase
    rd_en        = (phase != PH_WRITE);
    wr_en        = (phase == PH_WRITE);
    bus_wdata_oe = wr_en;
    bus_wdata    = res_reg;
    io_stb       = wr_en && (b_reg >= IO_BASE);
  end

  assert_no_bus_fight_R8: assert property (@(posedge clk) disable iff (rst)
    bus_wdata_oe |-> (wr_en && !rd_en));

  assert_write_after_read_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(rd_en));

  assert_write_value_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en) |-> (bus_wdata == DATA_W'($past(bus_rdata) - opa_reg)));

  assert_zero_jumps_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bus_wdata == '0) |=> (bus_addr == $past(c_reg)));

  assert_io_in_write_R7: assert property (@(posedge clk) disable iff (rst)
    io_stb |-> wr_en);
endmodule

// File: tb/oisc_core_tb.sv
`timescale 1ns/1ps
module oisc_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr, bus_rdata, bus_wdata;
  logic       bus_wdata_oe, rd_en, wr_en, io_stb;
  logic [7:0] mem [256];
  int         n_chk = 0;
  int         n_fail = 0;
  int         fight_cnt = 0;

  always #2.5 clk = ~clk;

  oisc_core u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe), .rd_en(rd_en),
    .wr_en(wr_en), .io_stb(io_stb)
  );

  assign bus_rdata = rd_en ? mem[bus_addr] : 8'hFF;

  always @(posedge clk) if (wr_en) mem[bus_addr] <= bus_wdata;

  // R8 monitor: drive enable without write, or overlapping a read
  always @(negedge clk) if (!rst && bus_wdata_oe && (rd_en || !wr_en)) fight_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_and_reset();
    rst = 1'b1;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic release_reset();
    rst = 1'b0;
  endtask

  // one instruction at address 0; samples each of its six clocks
  task automatic exec_one(input string tag, input logic [7:0] pa, pb, pc, va, vb);
    logic [7:0] exp_res, exp_next, exp_addr;
    logic       exp_le;
    clear_and_reset();
    mem[0] = pa; mem[1] = pb; mem[2] = pc; mem[pa] = va; mem[pb] = vb;
    exp_res  = vb - va;
    exp_le   = ($signed(vb) <= $signed(va));
    exp_next = exp_le ? pc : 8'd3;
    release_reset();
    for (int k = 0; k < 6; k++) begin
      case (k)
        0: exp_addr = 8'd0;
        1: exp_addr = 8'd1;
        2: exp_addr = 8'd2;
        3: exp_addr = pa;
        default: exp_addr = pb;
      endcase
      chk({tag, " R2 addr"}, bus_addr, exp_addr);
      chk({tag, " R2 rd_en"}, rd_en, (k < 5) ? 1 : 0);
      chk({tag, " R2 wr_en"}, wr_en, (k == 5) ? 1 : 0);
      chk({tag, " R7 io_stb"}, io_stb, (k == 5 && pb >= 8'd248) ? 1 : 0);
      if (k == 5) chk({tag, " R3 wdata"}, bus_wdata, exp_res);
      @(negedge clk);
    end
    chk({tag, exp_le ? " R5 next fetch" : " R4 next fetch"}, bus_addr, exp_next);
    chk({tag, " R3 stored"}, mem[pb], exp_res);
  endtask

  task automatic t_reset();
    clear_and_reset();
    mem[0] = 8'd20; mem[1] = 8'd21; mem[2] = 8'd30;
    chk("R1 addr in reset", bus_addr, 0);
    chk("R1 wr_en in reset", wr_en, 0);
    release_reset();
    repeat (4) @(negedge clk);
    chk("R1 mid-run read", rd_en, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 restart addr", bus_addr, 0);
    chk("R1 restart rd_en", rd_en, 1);
    chk("R1 restart wr_en", wr_en, 0);
  endtask

  task automatic t_smoke();
    clear_and_reset();
    release_reset();
    for (int k = 0; k < 30; k++) begin
      if (k % 6 == 0) chk("R9 loop fetch addr", bus_addr, 0);
      if (k % 6 == 5) begin
        chk("R9 loop write", wr_en, 1);
        chk("R9 loop data", bus_wdata, 0);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_smoke();
    exec_one("fallthrough", 8'd16, 8'd17, 8'd40, 8'd3, 8'd10);
    exec_one("equal", 8'd16, 8'd17, 8'd40, 8'd5, 8'd5);
    exec_one("negative", 8'd16, 8'd17, 8'd44, 8'd7, 8'd2);
    exec_one("R6 zero-minus-min", 8'd16, 8'd17, 8'd50, 8'h80, 8'h00);
    exec_one("R6 min-minus-one", 8'd16, 8'd17, 8'd52, 8'h01, 8'h80);
    exec_one("R6 min-minus-min", 8'd16, 8'd17, 8'd54, 8'h80, 8'h80);
    exec_one("io window", 8'd16, 8'd255, 8'd60, 8'd1, 8'd9);
    exec_one("io edge", 8'd16, 8'd248, 8'd60, 8'd4, 8'd2);
    exec_one("below io", 8'd16, 8'd247, 8'd60, 8'd1, 8'd9);
    chk("R8 no bus fight", fight_cnt, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule